// File: doc/BRIEF.md
# Flash Command Interface with Status Byte

This block sits between a CPU bus and an on-chip flash array. The CPU writes command bytes into the flash address space. The controller decodes them, starts program and erase operations on a back-end engine, and keeps an 8-bit status byte. Each CPU read is steered either to the array data or to that status byte. Which one is returned depends on the current mode of the command sequencer, not on the address.

The back-end is reached through a small handshake. A one-cycle start pulse carries an operation code, an address and a data word. The back-end later answers with a one-cycle done pulse and a fail flag. The two error bits in the status byte are sticky. While either error bit is set, new program and erase requests are refused until the CPU clears the byte.

The sequencer has six states:
- `ST_ARRAY`: reads return array data.
- `ST_STATUS`: reads return status.
- `ST_PROG_SETUP`, `ST_BERS_SETUP`, `ST_AERS_SETUP`: the first byte of a two-write sequence has been accepted.
- `ST_BUSY`: an operation is running.

Its transitions are:
- From either idle state: 0xFF goes to `ST_ARRAY` and 0x70 goes to `ST_STATUS`. 0x40, 0x20 and 0xA7 go to their setup state, but only when both error bits are clear.
- `ST_PROG_SETUP` goes to `ST_BUSY` on any write.
- `ST_BERS_SETUP` and `ST_AERS_SETUP` go to `ST_BUSY` on 0xD0. Any other byte sends them to `ST_STATUS` as a bad command.
- `ST_BUSY` leaves on done. It goes to `ST_ARRAY` if 0xFF was the last mode byte written while busy, and to `ST_STATUS` otherwise.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, reads return array data. Once 0x70 is written, the status byte reads 0x80.
- R2: Reads return array data only in array mode. Array mode is entered by reset, by writing 0xFF, or at the end of an operation after a 0xFF was written during it. Writing 0x70 makes every address read the status byte.
- R3: Writing 0x40 and then any write (address A, data D) raises `be_start` for exactly one cycle, with `be_op`=2'b01, `be_addr`=A and `be_data`=D.
- R4: Writing 0x20 and then 0xD0 at address A starts a block erase (`be_op`=2'b10, `be_addr`=A). Writing 0xA7 and then 0xD0 starts an erase of the whole array (`be_op`=2'b11).
- R5: Status bit 7 is 0 from the cycle after the start write until done returns, and is 1 otherwise. Reads return status from the start write until a 0xFF is written.
- R6: A done with fail set sets status bit 4 if the operation was a program, and bit 5 if it was an erase. Both bits stay set until cleared.
- R7: Writing 0x50 from an idle state clears bits 5 and 4 and leaves the read mode unchanged.
- R8: While bit 5 or bit 4 is 1, the bytes 0x40, 0x20 and 0xA7 start nothing and leave the status unchanged.
- R9: Outside busy and program setup, a byte that is not a recognised command sets bits 5 and 4. This includes 0xD0 alone and a wrong confirm byte after 0x20 or 0xA7.
- R10: While busy, every write is ignored except 0xFF and 0x70. Of those two, the last one written decides whether array mode or status mode follows done.
- R11: Status bits 6 and 3 to 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | CPU write strobe, one write per cycle |
| bus_addr | input | ADDR_W | CPU address |
| bus_wdata | input | DATA_W | CPU write data; the command byte is bits 7:0 |
| arr_rdata | input | DATA_W | Data read from the flash array at bus_addr |
| rd_data | output | DATA_W | CPU read data: array data or the zero-extended status byte |
| be_start | output | 1 | One-cycle start pulse to the back-end |
| be_op | output | 2 | Operation: 01 program, 10 block erase, 11 erase all |
| be_addr | output | ADDR_W | Operation address |
| be_data | output | DATA_W | Program data |
| be_done | input | 1 | One-cycle completion pulse from the back-end |
| be_fail | input | 1 | Failure flag, valid together with be_done |

## Verification
The assertions assume three things about the back-end:
- It answers each start with exactly one done pulse.
- That pulse comes at least one cycle after it has seen the start.
- It never raises done while no operation is outstanding.

The bench's behavioural back-end keeps within these assumptions. It loads a latency counter only on a start pulse and emits done only when that counter runs out. The bench also writes at most once per cycle and keeps `bus_wr` low between writes. It picks its busy-time writes so that all of them fall well inside the configured latency.

// File: rtl/flc_pkg.sv
package flc_pkg;

    typedef enum logic [2:0] {
        ST_ARRAY,
        ST_STATUS,
        ST_PROG_SETUP,
        ST_BERS_SETUP,
        ST_AERS_SETUP,
        ST_BUSY
    } flc_state_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_PROG = 2'b01,
        OP_BERS = 2'b10,
        OP_AERS = 2'b11
    } flc_op_e;

    typedef enum logic [2:0] {
        CMD_RD_ARRAY,
        CMD_RD_STATUS,
        CMD_CLEAR,
        CMD_PROG,
        CMD_BERS,
        CMD_AERS,
        CMD_CONFIRM,
        CMD_BAD
    } flc_cmd_e;

    localparam int CMD_W = 8;

    function automatic flc_cmd_e flc_decode(input logic [CMD_W-1:0] b);
        flc_cmd_e c;
        case (b)
            8'hFF:   c = CMD_RD_ARRAY;
            8'h70:   c = CMD_RD_STATUS;
            8'h50:   c = CMD_CLEAR;
            8'h40:   c = CMD_PROG;
            8'h20:   c = CMD_BERS;
            8'hA7:   c = CMD_AERS;
            8'hD0:   c = CMD_CONFIRM;
            default: c = CMD_BAD;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/flc_status.sv
module flc_status
    import flc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       bad_i,
    input  logic       done_i,
    input  logic       fail_i,
    input  flc_op_e    op_i,
    input  logic       ready_i,
    output logic [7:0] status_o
);

    logic err_erase_q;
    logic err_prog_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_erase_q <= 1'b0;
            err_prog_q  <= 1'b0;
        end else if (clr_i) begin
            err_erase_q <= 1'b0;
            err_prog_q  <= 1'b0;
        end else begin
            if (bad_i) begin
                err_erase_q <= 1'b1;
                err_prog_q  <= 1'b1;
            end
            if (done_i && fail_i) begin
                if (op_i == OP_PROG) err_prog_q  <= 1'b1;
                else                 err_erase_q <= 1'b1;
            end
        end
    end

    assign status_o = {ready_i, 1'b0, err_erase_q, err_prog_q, 4'b0000};

    AST_PROG_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_prog_q && !clr_i) |=> err_prog_q); // R6
    AST_ERASE_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_erase_q && !clr_i) |=> err_erase_q); // R6
    AST_CLEAR_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!err_prog_q && !err_erase_q)); // R7

endmodule

// File: rtl/flc_seq.sv
module flc_seq
    import flc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              err_any_i,
    input  logic              be_done_i,
    output logic              rd_status_o,
    output logic              ready_o,
    output logic              clr_o,
    output logic              bad_o,
    output logic              done_ack_o,
    output logic              be_start_o,
    output flc_op_e           be_op_o,
    output logic [ADDR_W-1:0] be_addr_o,
    output logic [DATA_W-1:0] be_data_o
);

    flc_state_e st_q, st_nxt;
    logic       ret_arr_q, ret_arr_nxt;
    logic       launch;
    flc_op_e    launch_op;
    flc_cmd_e   cmd;

    assign cmd        = flc_decode(wdata_i[CMD_W-1:0]);
    assign done_ack_o = be_done_i && (st_q == ST_BUSY);

    always_comb begin
        st_nxt      = st_q;
        ret_arr_nxt = ret_arr_q;
        clr_o       = 1'b0;
        bad_o       = 1'b0;
        launch      = 1'b0;
        launch_op   = OP_NONE;
        if (wr_i) begin
            unique case (st_q)
                ST_ARRAY, ST_STATUS: begin
                    unique case (cmd)
                        CMD_RD_ARRAY:  st_nxt = ST_ARRAY;
                        CMD_RD_STATUS: st_nxt = ST_STATUS;
                        CMD_CLEAR:     clr_o  = 1'b1;
                        CMD_PROG:      if (!err_any_i) st_nxt = ST_PROG_SETUP;
                        CMD_BERS:      if (!err_any_i) st_nxt = ST_BERS_SETUP;
                        CMD_AERS:      if (!err_any_i) st_nxt = ST_AERS_SETUP;
                        default:       bad_o  = 1'b1;
                    endcase
                end
                ST_PROG_SETUP: begin
                    st_nxt      = ST_BUSY;
                    launch      = 1'b1;
                    launch_op   = OP_PROG;
                    ret_arr_nxt = 1'b0;
                end
                ST_BERS_SETUP, ST_AERS_SETUP: begin
                    if (cmd == CMD_CONFIRM) begin
                        st_nxt      = ST_BUSY;
                        launch      = 1'b1;
                        launch_op   = (st_q == ST_BERS_SETUP) ? OP_BERS : OP_AERS;
                        ret_arr_nxt = 1'b0;
                    end else begin
                        st_nxt = ST_STATUS;
                        bad_o  = 1'b1;
                    end
                end
                ST_BUSY: begin
                    if (cmd == CMD_RD_ARRAY)       ret_arr_nxt = 1'b1;
                    else if (cmd == CMD_RD_STATUS) ret_arr_nxt = 1'b0;
                end
                default: st_nxt = ST_STATUS;
            endcase
        end
        if (done_ack_o) st_nxt = ret_arr_nxt ? ST_ARRAY : ST_STATUS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= ST_ARRAY;
            ret_arr_q <= 1'b0;
        end else begin
            st_q      <= st_nxt;
            ret_arr_q <= ret_arr_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            be_start_o <= 1'b0;
            be_op_o    <= OP_NONE;
            be_addr_o  <= '0;
            be_data_o  <= '0;
        end else begin
            be_start_o <= launch;
            if (launch) begin
                be_op_o   <= launch_op;
                be_addr_o <= addr_i;
                be_data_o <= wdata_i;
            end
        end
    end

    assign rd_status_o = (st_q != ST_ARRAY);
    assign ready_o     = (st_q != ST_BUSY);

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        be_start_o |=> !be_start_o); // R3
    AST_START_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        be_start_o |-> !ready_o); // R5
    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        done_ack_o |=> ready_o); // R5

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              be_start,
    output logic [1:0]        be_op,
    output logic [ADDR_W-1:0] be_addr,
    output logic [DATA_W-1:0] be_data,
    input  logic              be_done,
    input  logic              be_fail
);

    localparam int STAT_W = 8;

    logic [STAT_W-1:0] stat;
    logic              rd_status, ready, clr, bad, done_ack;
    flc_op_e           op_q;

    flc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (bus_wr),
        .addr_i      (bus_addr),
        .wdata_i     (bus_wdata),
        .err_any_i   (stat[5] | stat[4]),
        .be_done_i   (be_done),
        .rd_status_o (rd_status),
        .ready_o     (ready),
        .clr_o       (clr),
        .bad_o       (bad),
        .done_ack_o  (done_ack),
        .be_start_o  (be_start),
        .be_op_o     (op_q),
        .be_addr_o   (be_addr),
        .be_data_o   (be_data)
    );

    flc_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr),
        .bad_i    (bad),
        .done_i   (done_ack),
        .fail_i   (be_fail),
        .op_i     (op_q),
        .ready_i  (ready),
        .status_o (stat)
    );

    assign be_op = op_q;

    always_comb begin
        if (rd_status) begin
            rd_data             = '0;
            rd_data[STAT_W-1:0] = stat;
        end else begin
            rd_data = arr_rdata;
        end
    end

    AST_START_NEEDS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        be_start |-> (stat[5:4] == 2'b00)); // R8
    AST_BAD_SETS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        bad |=> (stat[5:4] == 2'b11)); // R9

endmodule

// File: tb/tb_flash_cmd_ctrl.sv
`timescale 1ns/100ps
module tb_flash_cmd_ctrl;

    localparam int AW  = 16;
    localparam int DW  = 8;
    localparam int LAT = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] arr_rdata, rd_data, be_data;
    logic          be_start, be_done, be_fail;
    logic [1:0]    be_op;
    logic [AW-1:0] be_addr;

    int   checks = 0;
    int   errors = 0;
    int   starts = 0;
    logic inject = 1'b0;
    int   cnt = 0;
    logic [1:0]    cap_op;
    logic [AW-1:0] cap_addr;
    logic [DW-1:0] cap_data;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] arr_of(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction
    assign arr_rdata = arr_of(bus_addr);

    flash_cmd_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .arr_rdata(arr_rdata), .rd_data(rd_data),
        .be_start(be_start), .be_op(be_op), .be_addr(be_addr), .be_data(be_data),
        .be_done(be_done), .be_fail(be_fail)
    );

    // behavioural back-end
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            be_done <= 1'b0; be_fail <= 1'b0; cnt <= 0;
        end else begin
            be_done <= 1'b0;
            be_fail <= 1'b0;
            if (be_start) begin
                cnt      <= LAT;
                starts   <= starts + 1;
                cap_op   <= be_op;
                cap_addr <= be_addr;
                cap_data <= be_data;
            end else if (cnt != 0) begin
                cnt <= cnt - 1;
                if (cnt == 1) begin
                    be_done <= 1'b1;
                    be_fail <= inject;
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wait_ready();
        logic [7:0] v;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            rd(16'h0000, v);
            if (v[7] && cnt == 0 && !be_done) return;
        end
        chk("R5 ready timeout", 0, 1);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(16'h1234, v);
        chk("R1 array after reset", v, arr_of(16'h1234));
        wr(16'h0000, 8'h70);
        rd(16'h1234, v);
        chk("R1 status 0x80", v, 8'h80);
    endtask

    task automatic t_modes();
        logic [7:0] v;
        wr(16'h0010, 8'hFF);
        rd(16'h0ABC, v); chk("R2 array A", v, arr_of(16'h0ABC));
        rd(16'hF00F, v); chk("R2 array B", v, arr_of(16'hF00F));
        wr(16'h0010, 8'h70);
        rd(16'h0ABC, v); chk("R2 status any addr A", v, 8'h80);
        rd(16'hF00F, v); chk("R2 status any addr B", v, 8'h80);
    endtask

    task automatic t_program();
        logic [7:0] v;
        int s0 = starts;
        wr(16'h0000, 8'hFF);
        wr(16'h0000, 8'h40);
        rd(16'h0300, v); chk("R2 status in setup", v, 8'h80);
        wr(16'h0456, 8'h3C);
        chk("R3 start pulse", be_start, 1);
        rd(16'h0456, v); chk("R5 busy status", v, 8'h00);
        @(negedge clk);
        chk("R3 start one cycle", be_start, 0);
        wait_ready();
        chk("R3 one start", starts - s0, 1);
        chk("R3 op", cap_op, 2'b01);
        chk("R3 addr", cap_addr, 16'h0456);
        chk("R3 data", cap_data, 8'h3C);
        rd(16'h0456, v); chk("R5 status after done", v, 8'h80);
        wr(16'h0000, 8'hFF);
        rd(16'h0456, v); chk("R2 array after FF", v, arr_of(16'h0456));
    endtask

    task automatic t_erase();
        logic [7:0] v;
        wr(16'h0000, 8'h20);
        wr(16'h0800, 8'hD0);
        wait_ready();
        chk("R4 block op", cap_op, 2'b10);
        chk("R4 block addr", cap_addr, 16'h0800);
        wr(16'h0000, 8'hA7);
        wr(16'h0000, 8'hD0);
        wait_ready();
        chk("R4 all op", cap_op, 2'b11);
        rd(16'h0000, v); chk("R4 status clean", v, 8'h80);
    endtask

    task automatic t_fail();
        logic [7:0] v;
        int s0;
        inject = 1'b1;
        wr(16'h0000, 8'h40);
        wr(16'h0100, 8'h55);
        wait_ready();
        inject = 1'b0;
        rd(16'h0000, v); chk("R6 program fail bit4", v, 8'h90);
        s0 = starts;
        wr(16'h0000, 8'h40);
        wr(16'h0000, 8'hA7);
        wr(16'h0000, 8'h20);
        repeat (3) @(negedge clk);
        chk("R8 no start with error", starts - s0, 0);
        rd(16'h0000, v); chk("R8 status unchanged", v, 8'h90);
        wr(16'h0000, 8'h50);
        rd(16'h0000, v); chk("R7 cleared", v, 8'h80);
        inject = 1'b1;
        wr(16'h0000, 8'h20);
        wr(16'h0200, 8'hD0);
        wait_ready();
        inject = 1'b0;
        rd(16'h0000, v); chk("R6 erase fail bit5", v, 8'hA0);
        wr(16'h0000, 8'hFF);
        wr(16'h0000, 8'h50);
        rd(16'h0042, v); chk("R7 mode kept", v, arr_of(16'h0042));
        wr(16'h0000, 8'h70);
        rd(16'h0000, v); chk("R7 cleared after erase", v, 8'h80);
    endtask

    task automatic t_bad();
        logic [7:0] v;
        int s0 = starts;
        wr(16'h0000, 8'h33);
        rd(16'h0000, v); chk("R9 bad command", v, 8'hB0);
        chk("R11 reserved zero", v & 8'h4F, 8'h00);
        wr(16'h0000, 8'h50);
        wr(16'h0000, 8'hD0);
        rd(16'h0000, v); chk("R9 lone confirm", v, 8'hB0);
        wr(16'h0000, 8'h50);
        wr(16'h0000, 8'h20);
        wr(16'h0000, 8'h55);
        repeat (2) @(negedge clk);
        rd(16'h0000, v); chk("R9 wrong confirm", v, 8'hB0);
        chk("R9 no start", starts - s0, 0);
        wr(16'h0000, 8'h50);
    endtask

    task automatic t_busy();
        logic [7:0] v;
        int s0 = starts;
        wr(16'h0000, 8'h40);
        wr(16'h0120, 8'h0F);
        wr(16'h0000, 8'h33);
        wr(16'h0000, 8'h40);
        wr(16'h0000, 8'hFF);
        wait_ready();
        chk("R10 single start", starts - s0, 1);
        rd(16'h0777, v); chk("R10 FF in busy gives array", v, arr_of(16'h0777));
        wr(16'h0000, 8'h70);
        rd(16'h0000, v); chk("R10 busy writes ignored", v, 8'h80);
        wr(16'h0000, 8'hA7);
        wr(16'h0000, 8'hD0);
        wr(16'h0000, 8'hFF);
        wr(16'h0000, 8'h70);
        wait_ready();
        rd(16'h0777, v); chk("R10 last 70 keeps status", v, 8'h80);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        t_reset();
        t_modes();
        t_program();
        t_erase();
        t_fail();
        t_bad();
        t_busy();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule